// File: doc/BRIEF.md
# Interrupt-Capable GPIO Register Block

This block gives a processor word-addressed control over a bank of general-purpose pins. The pins number fewer than 32. Each pin has an output latch, which software changes through write-only set and clear strobes, so that no read-modify-write sequence is needed. A direction register decides which pins are driven. Whether a 1 in that register means "drive" or "float" is fixed when the block is built. The input pins pass through a two-flop synchronizer, and the result can be read back through the bus.

Every pin can raise an interrupt request. Software chooses the detection kind (level or single edge) and the active sense (high/rising or low/falling) for each pin. An enable bit lets detection take place at all, and a separate mask bit decides whether a pending request reaches the single combined interrupt line. Edge requests stay pending until software acknowledges them by writing 1 to their bit. Level requests follow the pin. To catch both edges, software flips a pin's polarity after each event.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_out` is 0, `irq` is low, and `pin_drive` equals the direction register (0) taken through the build-time sense.
- R2: Writing the set register (byte offset 0x0C) drives high every latch bit written as 1 and leaves the bits written as 0 unchanged. The latch changes only through the set and clear registers, and both of them read as 0.
- R3: Writing the clear register (byte offset 0x10) drives low every latch bit written as 1 and leaves the other bits unchanged.
- R4: The direction register (offset 0x00) reads back what was written. With `OE_INVERT`=0 a 1 bit sets the matching `pin_drive` bit. With `OE_INVERT`=1 a 1 bit clears it.
- R5: The input register (offset 0x04) returns `pin_in` two clocks after it changes. Writes to that register have no effect.
- R6: For a pin with type bit 0 (edge, offset 0x18), a polarity bit of 1 (offset 0x1C) sets the pending bit on a rising edge and a polarity bit of 0 sets it on a falling edge. The opposite edge leaves it alone, and the bit stays set after the pin returns.
- R7: Writing 1 to a bit of the pending register (offset 0x20) clears an edge request, and 0 bits are untouched. If a new qualifying edge is detected in the same cycle as the clear, the bit stays set.
- R8: For a pin with type bit 1 (level), the pending bit is 1 exactly while the synchronized input equals the polarity bit. Writes to the pending register do not change it.
- R9: `irq` is high exactly when some pin has its pending, enable (offset 0x14) and mask (offset 0x24) bits all set.
- R10: While a pin's enable bit is 0, its pending bit never becomes 1. This holds through input edges and through changes to its type and polarity bits.
- R11: `NUM_PINS` must lie between 1 and 31. Register bits at and above `NUM_PINS` read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address, used for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_out | output | NUM_PINS | Output latch |
| pin_drive | output | NUM_PINS | Per-pin driver enable, 1 = driven |
| irq | output | 1 | Combined interrupt request |

## Verification
An acknowledge write to the pending register can land in the same clock as a fresh qualifying edge on the same pin. The bench sets up this collision by changing the pin one cycle before its synchronized value moves. It then holds the acknowledge write across the exact cycle in which the edge detector fires, so the clearing and the setting of the bit meet at one clock edge. The bench expects the request to survive, then acknowledges it a second time with no edge present and expects it to clear, which separates a correct priority from a stuck bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned BUS_W = 32;

   // byte offsets of the register window
   localparam logic [7:0] OFS_DIR   = 8'h00;
   localparam logic [7:0] OFS_INP   = 8'h04;
   localparam logic [7:0] OFS_SET   = 8'h0C;
   localparam logic [7:0] OFS_CLR   = 8'h10;
   localparam logic [7:0] OFS_ENA   = 8'h14;
   localparam logic [7:0] OFS_KIND  = 8'h18;
   localparam logic [7:0] OFS_SENSE = 8'h1C;
   localparam logic [7:0] OFS_PEND  = 8'h20;
   localparam logic [7:0] OFS_MASK  = 8'h24;

   typedef enum logic [3:0] {
      SEL_DIR,
      SEL_INP,
      SEL_SET,
      SEL_CLR,
      SEL_ENA,
      SEL_KIND,
      SEL_SENSE,
      SEL_PEND,
      SEL_MASK,
      SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
      reg_sel_e sel;
      case (ofs)
         OFS_DIR:   sel = SEL_DIR;
         OFS_INP:   sel = SEL_INP;
         OFS_SET:   sel = SEL_SET;
         OFS_CLR:   sel = SEL_CLR;
         OFS_ENA:   sel = SEL_ENA;
         OFS_KIND:  sel = SEL_KIND;
         OFS_SENSE: sel = SEL_SENSE;
         OFS_PEND:  sel = SEL_PEND;
         OFS_MASK:  sel = SEL_MASK;
         default:   sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync_bank: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[LAST];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int unsigned NUM_PINS  = 16,
   parameter bit          OE_INVERT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] set_stb,
   input  logic [NUM_PINS-1:0] clr_stb,
   input  logic [NUM_PINS-1:0] dir_bits,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_drive
);

   logic [NUM_PINS-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q | set_stb) & ~clr_stb;
   end

   assign pin_out = latch_q;

   if (OE_INVERT) begin : g_dir_active_low
      assign pin_drive = ~dir_bits;
   end else begin : g_dir_active_high
      assign pin_drive = dir_bits;
   end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned NUM_PINS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_s,
   input  logic [NUM_PINS-1:0] ena,
   input  logic [NUM_PINS-1:0] kind_level,
   input  logic [NUM_PINS-1:0] sense_hi,
   input  logic [NUM_PINS-1:0] ack,
   output logic [NUM_PINS-1:0] pend
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic prev_q;
      logic latched_q;
      logic rise;
      logic fall;
      logic hit;
      logic lvl_match;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= pin_s[i];
      end

      assign rise      = pin_s[i] & ~prev_q;
      assign fall      = ~pin_s[i] & prev_q;
      assign hit       = ena[i] & ~kind_level[i] & (sense_hi[i] ? rise : fall);
      assign lvl_match = ena[i] & kind_level[i] & (pin_s[i] == sense_hi[i]);

      // a fresh edge outranks an acknowledge arriving in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             latched_q <= 1'b0;
         else if (kind_level[i]) latched_q <= 1'b0;
         else if (hit)           latched_q <= 1'b1;
         else if (ack[i])        latched_q <= 1'b0;
      end

      assign pend[i] = kind_level[i] ? lvl_match : latched_q;
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter bit          OE_INVERT   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_drive,
   output logic                irq
);

   localparam int unsigned PAD_W = BUS_W - NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > 31) begin : g_bad_pins
      $error("gpio_irq_ctrl: NUM_PINS must be 1..31");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W must be at least 8");
   end

   // address qualification
   logic addr_hi_zero;
   if (ADDR_W > 8) begin : g_wide_addr
      assign addr_hi_zero = ~|reg_addr[ADDR_W-1:8];
   end else begin : g_narrow_addr
      assign addr_hi_zero = 1'b1;
   end

   reg_sel_e sel;
   reg_sel_e wr_sel;
   assign sel    = addr_hi_zero ? decode_offset(reg_addr[7:0]) : SEL_NONE;
   assign wr_sel = reg_we ? sel : SEL_NONE;

   logic [NUM_PINS-1:0] wd;
   assign wd = reg_wdata[NUM_PINS-1:0];

   // configuration registers
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] ena_q;
   logic [NUM_PINS-1:0] kind_q;
   logic [NUM_PINS-1:0] sense_q;
   logic [NUM_PINS-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         ena_q   <= '0;
         kind_q  <= '0;
         sense_q <= '0;
         mask_q  <= '0;
      end else begin
         case (wr_sel)
            SEL_DIR:   dir_q   <= wd;
            SEL_ENA:   ena_q   <= wd;
            SEL_KIND:  kind_q  <= wd;
            SEL_SENSE: sense_q <= wd;
            SEL_MASK:  mask_q  <= wd;
            default: ;
         endcase
      end
   end

   // strobes
   logic [NUM_PINS-1:0] set_stb;
   logic [NUM_PINS-1:0] clr_stb;
   logic [NUM_PINS-1:0] ack_stb;
   assign set_stb = (wr_sel == SEL_SET)  ? wd : '0;
   assign clr_stb = (wr_sel == SEL_CLR)  ? wd : '0;
   assign ack_stb = (wr_sel == SEL_PEND) ? wd : '0;

   gpio_out_latch #(
      .NUM_PINS  (NUM_PINS),
      .OE_INVERT (OE_INVERT)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_stb   (set_stb),
      .clr_stb   (clr_stb),
      .dir_bits  (dir_q),
      .pin_out   (pin_out),
      .pin_drive (pin_drive)
   );

   logic [NUM_PINS-1:0] pin_s;

   gpio_sync_bank #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_s)
   );

   logic [NUM_PINS-1:0] pend_vec;

   gpio_irq_detect #(
      .NUM_PINS (NUM_PINS)
   ) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (pin_s),
      .ena        (ena_q),
      .kind_level (kind_q),
      .sense_hi   (sense_q),
      .ack        (ack_stb),
      .pend       (pend_vec)
   );

   assign irq = |(pend_vec & ena_q & mask_q);

   // read path
   logic [NUM_PINS-1:0] rd_bits;
   always_comb begin
      case (sel)
         SEL_DIR:   rd_bits = dir_q;
         SEL_INP:   rd_bits = pin_s;
         SEL_ENA:   rd_bits = ena_q;
         SEL_KIND:  rd_bits = kind_q;
         SEL_SENSE: rd_bits = sense_q;
         SEL_PEND:  rd_bits = pend_vec;
         SEL_MASK:  rd_bits = mask_q;
         default:   rd_bits = '0;
      endcase
   end

   assign reg_rdata = {{PAD_W{1'b0}}, rd_bits};

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 16,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_we,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pend_vec,
   input logic [NUM_PINS-1:0] ena_q,
   input logic [NUM_PINS-1:0] mask_q,
   input logic                irq
);

   logic wr_set;
   logic wr_clr;
   assign wr_set = reg_we && (reg_addr == ADDR_W'(OFS_SET));
   assign wr_clr = reg_we && (reg_addr == ADDR_W'(OFS_CLR));

   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((pin_out & $past(reg_wdata[NUM_PINS-1:0])) == $past(reg_wdata[NUM_PINS-1:0]))); // R2

   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((pin_out & $past(reg_wdata[NUM_PINS-1:0])) == '0)); // R3

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(pin_out)); // R2

   AST_IRQ_NEEDS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((ena_q & mask_q) != '0)); // R9

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec == '0) |-> !irq); // R9

   AST_NO_PEND_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_vec & ~$past(pend_vec) & ~ena_q & ~$past(ena_q)) == '0)); // R10

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .pin_out   (pin_out),
   .pend_vec  (pend_vec),
   .ena_q     (ena_q),
   .mask_q    (mask_q),
   .irq       (irq)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

   localparam int N  = 16;
   localparam int AW = 8;

   localparam logic [7:0] A_DIR = 8'h00, A_INP = 8'h04, A_SET = 8'h0C, A_CLR = 8'h10,
                          A_ENA = 8'h14, A_KIND = 8'h18, A_SENSE = 8'h1C,
                          A_PEND = 8'h20, A_MASK = 8'h24;

   localparam int K_RDATA = 0, K_OUT = 1, K_IRQ = 2, K_DRIVE = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out;
   logic [N-1:0]  pin_drive;
   logic          irq;

   always #5 clk = ~clk;

   gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(AW), .OE_INVERT(1'b0), .SYNC_STAGES(2)) i_gpio_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_drive (pin_drive),
      .irq       (irq)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         item_t       it;
         logic [31:0] act;
         wait (sb.size() != 0);
         #2;
         it = sb.pop_front();
         case (it.kind)
            K_RDATA: act = reg_rdata;
            K_OUT:   act = 32'(pin_out);
            K_IRQ:   act = {31'd0, irq};
            default: act = 32'(pin_drive);
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push_exp(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      sb.push_back(it);
      wait (sb.size() == 0);
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      push_exp(K_RDATA, exp, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic pins(input logic [N-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_exp(A_DIR,   32'h0, "R1 dir");
      rd_exp(A_ENA,   32'h0, "R1 ena");
      rd_exp(A_KIND,  32'h0, "R1 kind");
      rd_exp(A_SENSE, 32'h0, "R1 sense");
      rd_exp(A_PEND,  32'h0, "R1 pend");
      rd_exp(A_MASK,  32'h0, "R1 mask");
      push_exp(K_OUT,   32'h0, "R1 pin_out");
      push_exp(K_IRQ,   32'h0, "R1 irq");
      push_exp(K_DRIVE, 32'h0, "R1 pin_drive");

      // R2 set strobe
      wr(A_SET, 32'h0000_00A5);
      push_exp(K_OUT, 32'h00A5, "R2 set");
      wr(A_SET, 32'h0000_0100);
      push_exp(K_OUT, 32'h01A5, "R2 zero bits keep");
      rd_exp(A_SET, 32'h0, "R2 set reads zero");

      // R3 clear strobe
      wr(A_CLR, 32'h0000_0005);
      push_exp(K_OUT, 32'h01A0, "R3 clear");
      rd_exp(A_CLR, 32'h0, "R3 clear reads zero");

      // R4 / R11 direction
      wr(A_DIR, 32'hFFFF_FFFF);
      rd_exp(A_DIR, 32'h0000_FFFF, "R11 upper bits zero");
      push_exp(K_DRIVE, 32'hFFFF, "R4 drive all");
      wr(A_DIR, 32'h0000_00F0);
      push_exp(K_DRIVE, 32'h00F0, "R4 drive some");
      push_exp(K_OUT, 32'h01A0, "R2 latch unchanged by dir");

      // R5 input sampling
      pins(16'h1234);
      rd_exp(A_INP, 32'h1234, "R5 input");
      wr(A_INP, 32'h0000_FFFF);
      rd_exp(A_INP, 32'h1234, "R5 write ignored");
      pins(16'h0000);

      // R10 config changes and edges while disabled
      wr(A_KIND, 32'h0001);
      wr(A_SENSE, 32'h0000);
      rd_exp(A_PEND, 32'h0, "R10 level match disabled");
      pins(16'h0008);
      pins(16'h0000);
      rd_exp(A_PEND, 32'h0, "R10 edge disabled");

      // R6 edges: pin1 rising, pin2 falling
      wr(A_SENSE, 32'h0002);
      wr(A_ENA,   32'h0006);
      pins(16'h0006);
      rd_exp(A_PEND, 32'h0002, "R6 rising only");
      push_exp(K_IRQ, 32'h0, "R9 masked");
      pins(16'h0000);
      rd_exp(A_PEND, 32'h0006, "R6 sticky plus falling");

      // R9 / R7 mask and acknowledge
      wr(A_MASK, 32'h0004);
      push_exp(K_IRQ, 32'h1, "R9 unmasked");
      wr(A_PEND, 32'h0004);
      rd_exp(A_PEND, 32'h0002, "R7 ack one bit");
      push_exp(K_IRQ, 32'h0, "R9 after ack");
      wr(A_MASK, 32'h0006);
      push_exp(K_IRQ, 32'h1, "R9 other pin");

      // R7 collision of acknowledge and new edge
      wr(A_PEND, 32'h0006);
      rd_exp(A_PEND, 32'h0, "R7 ack all");
      pins(16'h0002);
      pins(16'h0000);
      rd_exp(A_PEND, 32'h0002, "R6 opposite edge no effect");
      @(negedge clk);
      pin_in = 16'h0002;
      @(negedge clk);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = A_PEND;
      reg_wdata = 32'h0002;
      @(negedge clk);
      reg_we    = 1'b0;
      rd_exp(A_PEND, 32'h0002, "R7 edge wins over ack");
      wr(A_PEND, 32'h0002);
      rd_exp(A_PEND, 32'h0, "R7 ack without edge");

      // R8 level detection on pin0
      wr(A_SENSE, 32'h0003);
      wr(A_ENA,   32'h0007);
      rd_exp(A_PEND, 32'h0, "R8 level inactive");
      wr(A_MASK, 32'h0001);
      pins(16'h0003);
      rd_exp(A_PEND, 32'h0001, "R8 level high");
      push_exp(K_IRQ, 32'h1, "R9 level irq");
      wr(A_PEND, 32'h0001);
      rd_exp(A_PEND, 32'h0001, "R8 ack ignored");
      pins(16'h0002);
      rd_exp(A_PEND, 32'h0, "R8 level follows");
      push_exp(K_IRQ, 32'h0, "R9 level gone");
      wr(A_SENSE, 32'h0002);
      rd_exp(A_PEND, 32'h0001, "R8 active low");

      // R10 disable removes level request
      wr(A_ENA, 32'h0006);
      rd_exp(A_PEND, 32'h0, "R10 disabled level");
      push_exp(K_IRQ, 32'h0, "R9 disabled");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule